// File: doc/BRIEF.md
# DMA Transfer Configuration Validator

This block screens the transfer setup of one DMA channel at the moment software asks the channel to start. The inputs are the width codes for the read side and the write side, the two start addresses, the two per-burst address offsets, the source block byte count and a two-bit packing field. In the cycle that `start` is seen, the block checks every rule at once. If all rules hold, it grants a one-cycle `launch` pulse and holds `busy` until the mover reports completion. If any rule fails, it raises one sticky `usr_err` flag and issues nothing. The flag stays set, and further starts are refused, until `err_clr` is pulsed.

Once a configuration is accepted, the block latches the widths and the increment flags. It then drives the per-beat address step and a live address pointer for each side. On each `beat` the pointer either holds (fixed mode) or moves on by the data width, and it wraps at the top of the address space.

The control is a four-state machine:
- IDLE waits for `start`. IDLE→LAUNCH is taken when the configuration is legal, and IDLE→ERROR when it is not.
- LAUNCH lasts one cycle and drives `launch`. LAUNCH→RUN is unconditional.
- RUN waits for `xfer_done`. RUN→IDLE is taken on `xfer_done`.
- ERROR holds the flag. ERROR→IDLE is taken on `err_clr`.

Top module: `dma_cfg_validator`

## Requirements
- R1: Width codes are log2 of the byte width: 0 means 1 byte, 1 means 2, 2 means 4. Code 3 on either side is illegal: it gives `usr_err`=1 and no `launch`.
- R2: Taking the source width W in bytes, a block byte count whose low three bits are not a multiple of W is rejected with `usr_err`.
- R3: A source start address or source offset whose low three bits are not a multiple of the source width is rejected with `usr_err`.
- R4: A destination start address or destination offset whose low three bits are not a multiple of the destination width is rejected with `usr_err`.
- R5: When bit 1 of `pack_mode` is 1 and the two width codes differ, the block byte count must also be a multiple of the destination width. In every other case the destination width places no rule on the block count.
- R6: A legal configuration seen with `start` in IDLE gives `launch`=1 for exactly the one cycle after that edge. `busy` is 1 from that cycle until the edge that samples `xfer_done`.
- R7: `usr_err` stays set until `err_clr`. A `start` seen while it is set gives no `launch` and leaves the flag set.
- R8: When a configuration is accepted, each pointer loads its start address. On each `beat` in RUN, a pointer whose increment flag is 0 holds its value, and one whose flag is 1 adds the width in bytes, modulo 2^ADDR_W.
- R9: After acceptance, the step output is 0 when the increment flag is 0, and 1, 2 or 4 (the width in bytes) when it is 1.
- R10: After reset, `launch`, `busy`, `usr_err`, both pointers and both steps are 0.
- R11: A `start` seen while `busy` gives no new `launch` and does not reload the pointers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Channel start request |
| xfer_done | input | 1 | Transfer finished (honoured in RUN) |
| err_clr | input | 1 | Clears the user setting error |
| beat | input | 1 | One data beat completed (honoured in RUN) |
| src_wcode | input | 2 | Source width code |
| dst_wcode | input | 2 | Destination width code |
| src_inc | input | 1 | Source increment enable |
| dst_inc | input | 1 | Destination increment enable |
| pack_mode | input | 2 | Packing field; bit 1 enables packing |
| src_addr | input | ADDR_W | Source start address |
| dst_addr | input | ADDR_W | Destination start address |
| src_off | input | OFF_W | Source burst offset |
| dst_off | input | OFF_W | Destination burst offset |
| blk_bytes | input | BLK_W | Source block byte count |
| launch | output | 1 | One-cycle transfer grant |
| busy | output | 1 | Transfer in progress |
| usr_err | output | 1 | Sticky user setting error |
| src_ptr | output | ADDR_W | Current source address |
| dst_ptr | output | ADDR_W | Current destination address |
| src_step | output | ADDR_W | Source per-beat step |
| dst_step | output | ADDR_W | Destination per-beat step |

## Verification
The bench builds the block with its default parameters: 32-bit addresses and 16-bit offset and block fields. At these widths the upper bits of the address, offset and block inputs can be set non-zero. This shows that only the low bits decide alignment. With a start address of 0xFFFF_FFF8 and a word-wide incrementing source, the pointer wraps to zero within three beats. A table of width, alignment and packing combinations drives each rule in isolation and in legal mixes. Directed sequences then cover sticky error, refused restarts, and the fixed and incrementing pointer behaviour.

// File: rtl/dcv_pkg.sv
package dcv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_RUN    = 2'd2,
        ST_ERROR  = 2'd3
    } dcv_state_e;

    localparam logic [1:0] WCODE_ILLEGAL = 2'd3;

    // Byte-lane mask for a width code: width-1
    function automatic logic [2:0] wmask(input logic [1:0] code);
        unique case (code)
            2'd0:    wmask = 3'b000;
            2'd1:    wmask = 3'b001;
            2'd2:    wmask = 3'b011;
            default: wmask = 3'b111;
        endcase
    endfunction

    function automatic logic [2:0] wbytes(input logic [1:0] code);
        unique case (code)
            2'd0:    wbytes = 3'd1;
            2'd1:    wbytes = 3'd2;
            2'd2:    wbytes = 3'd4;
            default: wbytes = 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/dcv_side_chk.sv
module dcv_side_chk
    import dcv_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16,
    parameter int BLK_W  = 16
) (
    input  logic [1:0]        wcode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [OFF_W-1:0]  off,
    input  logic [BLK_W-1:0]  blk,
    input  logic              blk_chk_en,
    output logic              legal,
    output logic              ok
);

    logic [2:0]        m3;
    logic [ADDR_W-1:0] amask;
    logic [OFF_W-1:0]  omask;
    logic [BLK_W-1:0]  bmask;
    logic              addr_al, off_al, blk_al;

    always_comb begin
        m3    = wmask(wcode);
        amask = '0;
        omask = '0;
        bmask = '0;
        amask[2:0] = m3;
        omask[2:0] = m3;
        bmask[2:0] = m3;
        legal   = (wcode != WCODE_ILLEGAL);
        addr_al = ((addr & amask) == '0);
        off_al  = ((off  & omask) == '0);
        blk_al  = ((blk  & bmask) == '0);
        ok      = legal && addr_al && off_al && (!blk_chk_en || blk_al);
    end

    always_comb begin
        AST_ILLEGAL_NEVER_OK: assert (!(wcode == WCODE_ILLEGAL && ok)); // R1
    end

endmodule

// File: rtl/dcv_ptr.sv
module dcv_ptr
    import dcv_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [1:0]        load_wcode,
    input  logic              load_inc,
    input  logic              adv,
    output logic [ADDR_W-1:0] ptr,
    output logic [ADDR_W-1:0] step
);

    logic [1:0] wcode_q;
    logic       inc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcode_q <= '0;
            inc_q   <= 1'b0;
        end else if (load) begin
            wcode_q <= load_wcode;
            inc_q   <= load_inc;
        end
    end

    always_comb begin
        step = '0;
        if (inc_q) step[2:0] = wbytes(wcode_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     ptr <= '0;
        else if (load)  ptr <= load_addr;
        else if (adv)   ptr <= ptr + step;
    end

    AST_STEP_POW2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(step) <= 1); // R9
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !adv) |=> $stable(ptr)); // R8

endmodule

// File: rtl/dcv_ctrl.sv
module dcv_ctrl
    import dcv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic cfg_ok,
    input  logic xfer_done,
    input  logic err_clr,
    input  logic beat,
    output logic accept,
    output logic adv,
    output logic launch,
    output logic busy,
    output logic usr_err
);

    dcv_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = cfg_ok ? ST_LAUNCH : ST_ERROR;
            ST_LAUNCH: state_nx = ST_RUN;
            ST_RUN:    if (xfer_done) state_nx = ST_IDLE;
            ST_ERROR:  if (err_clr) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        accept  = (state == ST_IDLE) && start && cfg_ok;
        adv     = (state == ST_RUN) && beat;
        launch  = (state == ST_LAUNCH);
        busy    = (state == ST_LAUNCH) || (state == ST_RUN);
        usr_err = (state == ST_ERROR);
    end

    AST_LAUNCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> !launch); // R6
    AST_ERR_NO_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        usr_err |-> !launch && !busy); // R1
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (usr_err && !err_clr) |=> usr_err); // R7
    AST_BAD_CFG_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !usr_err && start && !cfg_ok) |=> usr_err); // R2
    AST_BUSY_NO_RELAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !launch) |=> !launch); // R11

endmodule

// File: rtl/dma_cfg_validator.sv
module dma_cfg_validator
    import dcv_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16,
    parameter int BLK_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              xfer_done,
    input  logic              err_clr,
    input  logic              beat,
    input  logic [1:0]        src_wcode,
    input  logic [1:0]        dst_wcode,
    input  logic              src_inc,
    input  logic              dst_inc,
    input  logic [1:0]        pack_mode,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [ADDR_W-1:0] dst_addr,
    input  logic [OFF_W-1:0]  src_off,
    input  logic [OFF_W-1:0]  dst_off,
    input  logic [BLK_W-1:0]  blk_bytes,
    output logic              launch,
    output logic              busy,
    output logic              usr_err,
    output logic [ADDR_W-1:0] src_ptr,
    output logic [ADDR_W-1:0] dst_ptr,
    output logic [ADDR_W-1:0] src_step,
    output logic [ADDR_W-1:0] dst_step
);

    localparam int NSIDE = 2;

    logic [1:0]        wc   [NSIDE];
    logic [ADDR_W-1:0] ad   [NSIDE];
    logic [OFF_W-1:0]  of   [NSIDE];
    logic              inc  [NSIDE];
    logic              bchk [NSIDE];
    logic              legal[NSIDE];
    logic              okv  [NSIDE];
    logic [ADDR_W-1:0] ptr  [NSIDE];
    logic [ADDR_W-1:0] stp  [NSIDE];

    logic pack_active, cfg_ok, accept, adv;
    logic unused_pack_lo;

    assign unused_pack_lo = pack_mode[0];
    assign pack_active    = pack_mode[1] && (src_wcode != dst_wcode);

    assign wc[0] = src_wcode;  assign wc[1] = dst_wcode;
    assign ad[0] = src_addr;   assign ad[1] = dst_addr;
    assign of[0] = src_off;    assign of[1] = dst_off;
    assign inc[0] = src_inc;   assign inc[1] = dst_inc;
    assign bchk[0] = 1'b1;     assign bchk[1] = pack_active;

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        dcv_side_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .BLK_W(BLK_W)) u_chk (
            .wcode      (wc[s]),
            .addr       (ad[s]),
            .off        (of[s]),
            .blk        (blk_bytes),
            .blk_chk_en (bchk[s]),
            .legal      (legal[s]),
            .ok         (okv[s])
        );
        dcv_ptr #(.ADDR_W(ADDR_W)) u_ptr (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (accept),
            .load_addr  (ad[s]),
            .load_wcode (wc[s]),
            .load_inc   (inc[s]),
            .adv        (adv),
            .ptr        (ptr[s]),
            .step       (stp[s])
        );
    end

    assign cfg_ok = okv[0] && okv[1];

    dcv_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cfg_ok    (cfg_ok),
        .xfer_done (xfer_done),
        .err_clr   (err_clr),
        .beat      (beat),
        .accept    (accept),
        .adv       (adv),
        .launch    (launch),
        .busy      (busy),
        .usr_err   (usr_err)
    );

    assign src_ptr  = ptr[0];
    assign dst_ptr  = ptr[1];
    assign src_step = stp[0];
    assign dst_step = stp[1];

    AST_ACCEPT_LEGAL_WIDTHS: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> legal[0] && legal[1]); // R1
    AST_LAUNCH_LOADS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (src_ptr == $past(src_addr)) && (dst_ptr == $past(dst_addr))); // R8

endmodule

// File: tb/dma_cfg_validator_test.sv
`timescale 1ns/1ps
module dma_cfg_validator_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 0, xfer_done = 0, err_clr = 0, beat = 0;
    logic [1:0]  src_wcode = 0, dst_wcode = 0, pack_mode = 0;
    logic        src_inc = 0, dst_inc = 0;
    logic [31:0] src_addr = 0, dst_addr = 0;
    logic [15:0] src_off = 0, dst_off = 0, blk_bytes = 0;
    logic        launch, busy, usr_err;
    logic [31:0] src_ptr, dst_ptr, src_step, dst_step;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    dma_cfg_validator uut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // {sw, dw, sa, so, da, do, blk, pack, ok}
    localparam int NV = 14;
    localparam logic [21:0] VEC [NV] = '{
        {2'd0,2'd0,3'd1,3'd3,3'd5,3'd7,3'd3,2'd0,1'b1}, // R1 legal bytes
        {2'd2,2'd2,3'd4,3'd0,3'd0,3'd4,3'd4,2'd0,1'b1}, // R3 R4 words aligned
        {2'd3,2'd0,3'd0,3'd0,3'd0,3'd0,3'd0,2'd0,1'b0}, // R1 src code 3
        {2'd0,2'd3,3'd0,3'd0,3'd0,3'd0,3'd0,2'd0,1'b0}, // R1 dst code 3
        {2'd2,2'd0,3'd0,3'd0,3'd3,3'd1,3'd2,2'd0,1'b0}, // R2 blk 2 vs word
        {2'd1,2'd1,3'd1,3'd0,3'd0,3'd0,3'd2,2'd0,1'b0}, // R3 src addr odd
        {2'd1,2'd1,3'd2,3'd3,3'd0,3'd0,3'd2,2'd0,1'b0}, // R3 src offset odd
        {2'd2,2'd1,3'd0,3'd0,3'd2,3'd1,3'd4,2'd0,1'b0}, // R4 dst offset odd
        {2'd1,2'd2,3'd0,3'd0,3'd2,3'd0,3'd2,2'd0,1'b0}, // R4 dst addr 2 vs word
        {2'd0,2'd2,3'd0,3'd0,3'd0,3'd0,3'd2,2'd2,1'b0}, // R5 packing blk vs dst
        {2'd0,2'd2,3'd0,3'd0,3'd0,3'd0,3'd2,2'd1,1'b1}, // R5 bit1 clear
        {2'd1,2'd1,3'd0,3'd0,3'd0,3'd0,3'd2,2'd2,1'b1}, // R5 equal widths
        {2'd2,2'd1,3'd4,3'd0,3'd2,3'd6,3'd4,2'd3,1'b1}, // R5 packing legal
        {2'd0,2'd1,3'd0,3'd0,3'd0,3'd0,3'd3,2'd2,1'b0}  // R5 blk 3 vs half
    };

    task automatic do_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic finish_run();
        @(negedge clk);                 // RUN
        xfer_done = 1'b1;
        @(negedge clk); xfer_done = 1'b0;
    endtask

    task automatic clear_err();
        err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
    endtask

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 launch", launch, 0);
        check("R10 busy", busy, 0);
        check("R10 usr_err", usr_err, 0);
        check("R10 src_ptr", src_ptr, 0);
        check("R10 dst_step", dst_step, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 idle after release", {launch, busy, usr_err}, 0);

        for (int i = 0; i < NV; i++) begin
            logic ok;
            {src_wcode, dst_wcode} = VEC[i][21:18];
            src_addr  = {29'h0ABC_0000 >> 3, VEC[i][17:15]};
            src_off   = {13'h1A0, VEC[i][14:12]};
            dst_addr  = {29'h1234_5670 >> 3, VEC[i][11:9]};
            dst_off   = {13'h0C8, VEC[i][8:6]};
            blk_bytes = {13'h040, VEC[i][5:3]};
            pack_mode = VEC[i][2:1];
            ok        = VEC[i][0];
            do_start();
            check($sformatf("R1-vector%0d launch", i), launch, ok);
            check($sformatf("R2-vector%0d usr_err", i), usr_err, !ok);
            if (ok) finish_run();
            else    clear_err();
            check($sformatf("R7-vector%0d back to idle", i), {busy, usr_err}, 0);
        end

        // R7: start while error is set is refused
        src_wcode = 2'd3; dst_wcode = 2'd0; pack_mode = 0;
        do_start();
        check("R7 error raised", usr_err, 1);
        src_wcode = 2'd0; src_addr = 0; src_off = 0; dst_addr = 0; dst_off = 0; blk_bytes = 0;
        do_start();
        check("R7 no launch while error", launch, 0);
        check("R7 flag held", usr_err, 1);
        repeat (3) @(negedge clk);
        check("R7 flag still held", usr_err, 1);
        clear_err();
        check("R7 cleared", usr_err, 0);

        // R6 R8 R9: accepted config, incrementing word source, fixed byte dest
        src_wcode = 2'd2; src_inc = 1; src_addr = 32'hFFFF_FFF8; src_off = 16'h0010;
        dst_wcode = 2'd0; dst_inc = 0; dst_addr = 32'h0000_1235; dst_off = 16'h0003;
        blk_bytes = 16'h0100; pack_mode = 2'd0;
        do_start();
        check("R6 launch pulse", launch, 1);
        check("R6 busy in launch", busy, 1);
        check("R8 src ptr loaded", src_ptr, 32'hFFFF_FFF8);
        check("R8 dst ptr loaded", dst_ptr, 32'h0000_1235);
        check("R9 src step word", src_step, 4);
        check("R9 dst step fixed", dst_step, 0);
        @(negedge clk);
        check("R6 launch gone", launch, 0);
        check("R6 busy in run", busy, 1);
        // R11: start while busy ignored
        src_addr = 32'h0000_0100;
        start = 1'b1; @(negedge clk); start = 1'b0;
        check("R11 no relaunch", launch, 0);
        check("R11 ptr not reloaded", src_ptr, 32'hFFFF_FFF8);
        for (int b = 1; b <= 3; b++) begin
            beat = 1'b1; @(negedge clk); beat = 1'b0;
            check($sformatf("R8 src ptr beat%0d", b), src_ptr, 32'hFFFF_FFF8 + 32'(4*b));
            check($sformatf("R8 dst ptr fixed beat%0d", b), dst_ptr, 32'h0000_1235);
        end
        xfer_done = 1'b1; @(negedge clk); xfer_done = 1'b0;
        check("R6 busy drops after done", busy, 0);

        // R9: halfword increments on destination
        src_wcode = 2'd0; src_inc = 0; src_addr = 32'h10; src_off = 0;
        dst_wcode = 2'd1; dst_inc = 1; dst_addr = 32'h20; dst_off = 16'h2;
        blk_bytes = 16'h6;
        do_start();
        check("R9 dst step half", dst_step, 2);
        check("R9 src step fixed", src_step, 0);
        @(negedge clk);
        beat = 1'b1; @(negedge clk); beat = 1'b0;
        check("R8 dst ptr half step", dst_ptr, 32'h22);
        check("R8 src ptr fixed", src_ptr, 32'h10);
        finish_run();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule